// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block buffers 18-bit words between two unrelated clock domains. The write and read clocks run freely, and they may be asynchronous to each other or the same clock. A producer stores a word when its pair of opposite-polarity write enables is in the accepting state and the block reports that it has room. A consumer takes the word held in a registered output when three active-low read qualifiers are all low and the block reports valid data.

When a word enters an empty buffer, it moves into the output register by itself, with no read request, after a fixed three read-clock latency. The consumer therefore always sees the head word before it commits to a read. One asynchronous reset clears both domains at once. The output register counts toward the 512-word capacity.

Tri-state outputs are not built. A drive-qualifier output shows when the data would be driven.

Top module: `dc_fwft_fifo`

## Requirements
- R1: The buffer holds exactly 512 unread words of 18 bits, the word in the output register included. Words leave in the order they were stored.
- R2: A word is stored on a rising `wclk` edge only if `wen_hi`=1, `wen_lo_n`=0 and `in_ready`=1. The other three enable combinations store nothing.
- R3: The head word is consumed on a rising `rclk` edge only if `rd_en_n`, `oe_a_n` and `oe_b_n` are all 0 and `out_ready`=1. If any one of them is 1, `out_ready` and `rdata` stay unchanged.
- R4: A word written into an empty buffer appears on `rdata` at the third rising `rclk` edge after the write edge, whatever the read qualifiers are. `out_ready` rises at that same edge and is still 0 after the second edge.
- R5: While `out_ready`=0, nothing is consumed and `rdata` keeps the last word that was read.
- R6: `in_ready` is 0 while `arst_n`=0. After release it is still 0 following the first rising `wclk` edge and is 1 following the second.
- R7: `arst_n`=0 forces `in_ready` and `out_ready` to 0 and discards all stored words. The reset must be held across at least four rising edges of each clock.
- R8: `q_drive` is 1 only when `oe_a_n`=0 and `oe_b_n`=0. While it is 0, no read takes place.
- R9: `in_ready` is 0 right after the `wclk` edge that stores the 512th unread word. It stays 0 until a consumed word has crossed the synchronizer, and then it returns to 1 within a few `wclk` edges.
- R10: With the two clocks at unrelated frequencies and irregular traffic on both sides, every stored word comes out once, unchanged and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst_n | input | 1 | Asynchronous reset, active low, shared by both domains |
| wclk | input | 1 | Write clock |
| wen_hi | input | 1 | Write enable, active high |
| wen_lo_n | input | 1 | Write enable, active low |
| wdata | input | 18 | Word to store |
| in_ready | output | 1 | Room available, registered on `wclk` |
| rclk | input | 1 | Read clock |
| rd_en_n | input | 1 | Read request, active low |
| oe_a_n | input | 1 | First output enable, active low |
| oe_b_n | input | 1 | Second output enable, active low |
| rdata | output | 18 | Registered head word |
| out_ready | output | 1 | `rdata` holds an unread word, registered on `rclk` |
| q_drive | output | 1 | Data would be driven (both output enables low) |

## Verification
A single write into an empty buffer, with every read qualifier held inactive, separates a correct three-edge fall-through latency from a latency that is one edge too short or too long. Holding exactly one read qualifier high at a time, with a second word queued behind the head, shows which qualifier a faulty design ignores, because a read it should not make would bring up the second word. The four combinations of write enables, followed by a drain, show whether anything other than the accepting combination stores a word. Filling to 512 with no reads, then running long irregular traffic under unrelated clocks against a queue model, separates off-by-one full detection and broken pointer crossing from correct ordering.

// File: rtl/fwft_pkg.sv
package fwft_pkg;
   localparam int DEF_DATA_W = 18;
   localparam int DEF_ADDR_W = 9;
   localparam int DEF_SYNC   = 2;

   function automatic logic [31:0] to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction
endpackage

// File: rtl/fwft_sync.sv
module fwft_sync #(
   parameter int W      = 10,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge arst_n)
            if (!arst_n) stg[g] <= '0;
            else         stg[g] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge arst_n)
            if (!arst_n) stg[g] <= '0;
            else         stg[g] <= stg[g-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/fwft_ram.sv
module fwft_ram #(
   parameter int DW = 18,
   parameter int AW = 9
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge wclk)
      if (we) cells[waddr] <= wdata;

   assign rdata = cells[raddr];
endmodule

// File: rtl/fwft_wr_ctrl.sv
module fwft_wr_ctrl #(
   parameter int AW   = 9,
   parameter int SYNC = 2,
   localparam int PW  = AW + 1
) (
   input  logic          wclk,
   input  logic          arst_n,
   input  logic          wen_hi,
   input  logic          wen_lo_n,
   input  logic [PW-1:0] pop_gray,
   output logic [PW-1:0] wptr_gray,
   output logic [AW-1:0] waddr,
   output logic          we,
   output logic          in_ready
);
   logic [PW-1:0] wbin, wbin_n, wgray_n, pop_sync, full_mark;
   logic          live, full_n;

   fwft_sync #(.W(PW), .STAGES(SYNC)) u_pop_sync (
      .clk(wclk), .arst_n(arst_n), .d(pop_gray), .q(pop_sync));

   assign we        = wen_hi & ~wen_lo_n & in_ready;
   assign wbin_n    = wbin + PW'(we);
   assign wgray_n   = PW'(fwft_pkg::to_gray(32'(wbin_n)));
   assign full_mark = {~pop_sync[PW-1:PW-2], pop_sync[PW-3:0]};
   assign full_n    = (wgray_n == full_mark);
   assign waddr     = wbin[AW-1:0];

   always_ff @(posedge wclk or negedge arst_n)
      if (!arst_n) begin
         wbin      <= '0;
         wptr_gray <= '0;
         live      <= 1'b0;
         in_ready  <= 1'b0;
      end else begin
         wbin      <= wbin_n;
         wptr_gray <= wgray_n;
         live      <= 1'b1;
         in_ready  <= live & ~full_n;
      end
endmodule

// File: rtl/fwft_rd_ctrl.sv
module fwft_rd_ctrl #(
   parameter int DW   = 18,
   parameter int AW   = 9,
   parameter int SYNC = 2,
   localparam int PW  = AW + 1
) (
   input  logic          rclk,
   input  logic          arst_n,
   input  logic          rd_en_n,
   input  logic          oe_a_n,
   input  logic          oe_b_n,
   input  logic [PW-1:0] wptr_gray,
   input  logic [DW-1:0] ram_q,
   output logic [AW-1:0] raddr,
   output logic [PW-1:0] pop_gray,
   output logic [DW-1:0] rdata,
   output logic          out_ready
);
   logic [PW-1:0] wsync, fbin, fgray, pbin, fbin_n, pbin_n;
   logic          empty, take, fill;

   fwft_sync #(.W(PW), .STAGES(SYNC)) u_wr_sync (
      .clk(rclk), .arst_n(arst_n), .d(wptr_gray), .q(wsync));

   assign empty  = (fgray == wsync);
   assign take   = out_ready & ~rd_en_n & ~oe_a_n & ~oe_b_n;
   assign fill   = ~empty & (~out_ready | take);
   assign fbin_n = fbin + PW'(fill);
   assign pbin_n = pbin + PW'(take);
   assign raddr  = fbin[AW-1:0];

   always_ff @(posedge rclk or negedge arst_n)
      if (!arst_n) begin
         fbin      <= '0;
         fgray     <= '0;
         pbin      <= '0;
         pop_gray  <= '0;
         rdata     <= '0;
         out_ready <= 1'b0;
      end else begin
         fbin      <= fbin_n;
         fgray     <= PW'(fwft_pkg::to_gray(32'(fbin_n)));
         pbin      <= pbin_n;
         pop_gray  <= PW'(fwft_pkg::to_gray(32'(pbin_n)));
         if (fill) rdata <= ram_q;
         out_ready <= fill | (out_ready & ~take);
      end
endmodule

// File: rtl/dc_fwft_fifo.sv
module dc_fwft_fifo #(
   parameter int DATA_W      = fwft_pkg::DEF_DATA_W,
   parameter int ADDR_W      = fwft_pkg::DEF_ADDR_W,
   parameter int SYNC_STAGES = fwft_pkg::DEF_SYNC
) (
   input  logic              arst_n,
   input  logic              wclk,
   input  logic              wen_hi,
   input  logic              wen_lo_n,
   input  logic [DATA_W-1:0] wdata,
   output logic              in_ready,
   input  logic              rclk,
   input  logic              rd_en_n,
   input  logic              oe_a_n,
   input  logic              oe_b_n,
   output logic [DATA_W-1:0] rdata,
   output logic              out_ready,
   output logic              q_drive
);
   localparam int PW = ADDR_W + 1;

   if (DATA_W < 1) begin : g_bad_data_w
      $error("dc_fwft_fifo: DATA_W must be at least 1");
   end
   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr_w
      $error("dc_fwft_fifo: ADDR_W must lie in 2..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dc_fwft_fifo: SYNC_STAGES must be at least 2");
   end

   logic [PW-1:0]     wptr_gray, pop_gray;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [DATA_W-1:0] ram_q;
   logic              we;

   fwft_wr_ctrl #(.AW(ADDR_W), .SYNC(SYNC_STAGES)) u_wr (
      .wclk(wclk), .arst_n(arst_n), .wen_hi(wen_hi), .wen_lo_n(wen_lo_n),
      .pop_gray(pop_gray), .wptr_gray(wptr_gray), .waddr(waddr), .we(we),
      .in_ready(in_ready));

   fwft_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
      .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(ram_q));

   fwft_rd_ctrl #(.DW(DATA_W), .AW(ADDR_W), .SYNC(SYNC_STAGES)) u_rd (
      .rclk(rclk), .arst_n(arst_n), .rd_en_n(rd_en_n), .oe_a_n(oe_a_n),
      .oe_b_n(oe_b_n), .wptr_gray(wptr_gray), .ram_q(ram_q), .raddr(raddr),
      .pop_gray(pop_gray), .rdata(rdata), .out_ready(out_ready));

   assign q_drive = ~oe_a_n & ~oe_b_n;
endmodule

// File: rtl/dc_fwft_fifo_chk.sv
module dc_fwft_fifo_chk #(
   parameter int DW = 18,
   parameter int PW = 10
) (
   input logic          arst_n,
   input logic          wclk,
   input logic          rclk,
   input logic          wen_hi,
   input logic          wen_lo_n,
   input logic          in_ready,
   input logic          rd_en_n,
   input logic          oe_a_n,
   input logic          oe_b_n,
   input logic [DW-1:0] rdata,
   input logic          out_ready,
   input logic          q_drive,
   input logic [PW-1:0] wptr_gray,
   input logic [PW-1:0] pop_gray
);
   // R2: the write pointer moves only when the enables accept
   p_no_store_blocked_r2: assert property (@(posedge wclk) disable iff (!arst_n)
      !(wen_hi && !wen_lo_n && in_ready) |=> $stable(wptr_gray));

   // R10: the crossing pointer changes by at most one bit per edge
   p_gray_step_r10: assert property (@(posedge wclk) disable iff (!arst_n)
      $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

   // R3: a head word survives any cycle with an inactive qualifier
   p_hold_head_r3: assert property (@(posedge rclk) disable iff (!arst_n)
      (out_ready && (rd_en_n || oe_a_n || oe_b_n)) |=> (out_ready && $stable(rdata)));

   // R5: after a read with nothing behind it, the last word stays on the output
   p_keep_last_r5: assert property (@(posedge rclk) disable iff (!arst_n)
      (out_ready && !rd_en_n && !oe_a_n && !oe_b_n) |=> (out_ready || $stable(rdata)));

   // R8: while the output is not driven, nothing is consumed
   p_undriven_no_pop_r8: assert property (@(posedge rclk) disable iff (!arst_n)
      !q_drive |=> $stable(pop_gray));

   // R7: flags stay low while reset is held
   always @(posedge wclk)
      if (!arst_n) p_reset_ir_r7: assert (!in_ready);
   always @(posedge rclk)
      if (!arst_n) p_reset_or_r7: assert (!out_ready);
endmodule

bind dc_fwft_fifo dc_fwft_fifo_chk #(.DW(DATA_W), .PW(ADDR_W + 1)) u_chk (
   .arst_n(arst_n), .wclk(wclk), .rclk(rclk), .wen_hi(wen_hi),
   .wen_lo_n(wen_lo_n), .in_ready(in_ready), .rd_en_n(rd_en_n),
   .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .rdata(rdata), .out_ready(out_ready),
   .q_drive(q_drive), .wptr_gray(wptr_gray), .pop_gray(pop_gray));

// File: tb/tb_dc_fwft_fifo.sv
`timescale 1ns/1ps
module tb_dc_fwft_fifo;
   localparam int WCLK_PERIOD = 10;
   localparam int RCLK_PERIOD = 14;
   localparam int DW    = 18;
   localparam int DEPTH = 512;

   logic          arst_n = 1'b0, wclk = 1'b0, rclk = 1'b0;
   logic          wen_hi = 1'b0, wen_lo_n = 1'b1;
   logic [DW-1:0] wdata = '0;
   logic          rd_en_n = 1'b1, oe_a_n = 1'b1, oe_b_n = 1'b1;
   logic          in_ready, out_ready, q_drive;
   logic [DW-1:0] rdata;

   int total = 0;
   int bad   = 0;
   logic [DW-1:0] model[$];

   dc_fwft_fifo dut (
      .arst_n(arst_n), .wclk(wclk), .wen_hi(wen_hi), .wen_lo_n(wen_lo_n),
      .wdata(wdata), .in_ready(in_ready), .rclk(rclk), .rd_en_n(rd_en_n),
      .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .rdata(rdata), .out_ready(out_ready),
      .q_drive(q_drive));

   always #(WCLK_PERIOD / 2) wclk = ~wclk;
   initial begin
      #1;
      forever #(RCLK_PERIOD / 2) rclk = ~rclk;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge wclk);
      arst_n = 1'b0; wen_hi = 1'b0; wen_lo_n = 1'b1;
      rd_en_n = 1'b1; oe_a_n = 1'b1; oe_b_n = 1'b1;
      repeat (6) @(posedge rclk);
      #1 check(!in_ready && !out_ready, "R7", "flags in reset",
               {30'd0, in_ready, out_ready}, 0);
      model.delete();
      @(negedge wclk) arst_n = 1'b1;
      @(posedge wclk);
      #1 check(in_ready == 1'b0, "R6", "in_ready after edge 1", 32'(in_ready), 0);
      @(posedge wclk);
      #1 check(in_ready == 1'b1, "R6", "in_ready after edge 2", 32'(in_ready), 1);
   endtask

   task automatic push_word(input logic [DW-1:0] d, input logic hi, input logic lo_n);
      @(negedge wclk);
      wen_hi = hi; wen_lo_n = lo_n; wdata = d;
      if (hi && !lo_n && in_ready) model.push_back(d);
      @(posedge wclk);
      #1 wen_hi = 1'b0; wen_lo_n = 1'b1;
   endtask

   task automatic pop_word(input string req);
      int waited;
      logic [DW-1:0] exp;
      waited = 0;
      @(negedge rclk);
      while (!out_ready && waited < 40) begin
         @(negedge rclk);
         waited++;
      end
      if (!out_ready || model.size() == 0) begin
         check(1'b0, req, "no head word", 32'(out_ready), 32'(model.size()));
         return;
      end
      exp = model.pop_front();
      check(rdata == exp, req, "head word", 32'(rdata), 32'(exp));
      rd_en_n = 1'b0; oe_a_n = 1'b0; oe_b_n = 1'b0;
      @(posedge rclk);
      #1 rd_en_n = 1'b1;
   endtask

   task automatic t_reset_flush();
      do_reset();
      push_word(18'h00011, 1'b1, 1'b0);
      push_word(18'h00022, 1'b1, 1'b0);
      repeat (8) @(posedge rclk);
      do_reset();
      repeat (6) @(posedge rclk);
      #1 check(out_ready == 1'b0, "R7", "stored words discarded", 32'(out_ready), 0);
      check(q_drive == 1'b0, "R8", "q_drive with enables high", 32'(q_drive), 0);
   endtask

   task automatic t_first_word();
      logic [DW-1:0] w;
      w = 18'h2A5C3;
      @(negedge wclk);
      wen_hi = 1'b1; wen_lo_n = 1'b0; wdata = w;
      model.push_back(w);
      @(posedge wclk);
      fork
         begin #2 wen_hi = 1'b0; wen_lo_n = 1'b1; end
      join_none
      repeat (2) @(posedge rclk);
      #1 check(out_ready == 1'b0, "R4", "out_ready after 2 rclk", 32'(out_ready), 0);
      @(posedge rclk);
      #1 check(out_ready == 1'b1, "R4", "out_ready after 3 rclk", 32'(out_ready), 1);
      check(rdata == w, "R4", "fall-through word", 32'(rdata), 32'(w));
      check(q_drive == 1'b0, "R8", "q_drive while enables high", 32'(q_drive), 0);
   endtask

   task automatic t_read_blocked();
      logic [DW-1:0] a, b;
      a = model[0];
      b = 18'h1B00B;
      push_word(b, 1'b1, 1'b0);
      repeat (6) @(posedge rclk);
      for (int k = 0; k < 3; k++) begin
         @(negedge rclk);
         rd_en_n = (k == 0); oe_a_n = (k == 1); oe_b_n = (k == 2);
         repeat (3) @(posedge rclk);
         #1 check(out_ready && rdata == a, "R3", "head kept, one qualifier high",
                  32'(rdata), 32'(a));
         if (k != 0) check(q_drive == 1'b0, "R8", "q_drive with one enable high",
                           32'(q_drive), 0);
      end
      pop_word("R3");
      pop_word("R3");
      repeat (3) @(posedge rclk);
      #1 check(out_ready == 1'b0, "R5", "out_ready after drain", 32'(out_ready), 0);
      check(rdata == b, "R5", "last word kept", 32'(rdata), 32'(b));
      @(negedge rclk);
      rd_en_n = 1'b0; oe_a_n = 1'b0; oe_b_n = 1'b0;
      repeat (4) @(posedge rclk);
      #1 check(rdata == b && !out_ready, "R5", "empty read ignored", 32'(rdata), 32'(b));
      check(q_drive == 1'b1, "R8", "q_drive with both enables low", 32'(q_drive), 1);
      rd_en_n = 1'b1;
      push_word(18'h0C0DE, 1'b1, 1'b0);
      pop_word("R5");
   endtask

   task automatic t_write_qual();
      push_word(18'h11111, 1'b1, 1'b1);
      push_word(18'h22222, 1'b0, 1'b0);
      push_word(18'h33333, 1'b0, 1'b1);
      push_word(18'h04444, 1'b1, 1'b0);
      repeat (6) @(posedge rclk);
      pop_word("R2");
      repeat (5) @(posedge rclk);
      #1 check(out_ready == 1'b0, "R2", "only the accepted word stored", 32'(out_ready), 0);
   endtask

   task automatic t_fill();
      int waited;
      do_reset();
      for (int i = 0; i < DEPTH; i++) begin
         if (i == DEPTH - 1) begin
            @(negedge wclk);
            check(in_ready == 1'b1, "R1", "room before word 512", 32'(in_ready), 1);
         end
         push_word(DW'(i * 37 + 5), 1'b1, 1'b0);
      end
      check(in_ready == 1'b0, "R9", "in_ready after word 512", 32'(in_ready), 0);
      push_word(18'h3FFFF, 1'b1, 1'b0);
      push_word(18'h3FFFE, 1'b1, 1'b0);
      repeat (10) @(posedge wclk);
      #1 check(in_ready == 1'b0, "R9", "in_ready held while full", 32'(in_ready), 0);
      pop_word("R1");
      check(in_ready == 1'b0, "R9", "in_ready right after pop", 32'(in_ready), 0);
      waited = 0;
      while (!in_ready && waited < 8) begin
         @(posedge wclk);
         #1 waited++;
      end
      check(in_ready == 1'b1, "R9", "in_ready back after pop", 32'(in_ready), 1);
      for (int i = 1; i < DEPTH; i++) pop_word("R1");
      repeat (4) @(posedge rclk);
      #1 check(out_ready == 1'b0, "R1", "empty after 512 reads", 32'(out_ready), 0);
   endtask

   task automatic t_stream();
      int n_words;
      n_words = 400;
      do_reset();
      @(negedge rclk);
      oe_a_n = 1'b0; oe_b_n = 1'b0;
      fork
         begin : writer
            int sent;
            sent = 0;
            while (sent < n_words) begin
               @(negedge wclk);
               if (($urandom % 3 != 0) && in_ready) begin
                  wen_hi = 1'b1; wen_lo_n = 1'b0;
                  wdata = DW'($urandom);
                  model.push_back(wdata);
                  sent++;
               end else begin
                  wen_hi = 1'b0; wen_lo_n = 1'b1;
               end
            end
            @(negedge wclk);
            wen_hi = 1'b0; wen_lo_n = 1'b1;
         end
         begin : reader
            int got;
            got = 0;
            while (got < n_words) begin
               @(negedge rclk);
               if (out_ready && ($urandom % 4 != 0) && model.size() != 0) begin
                  check(rdata == model[0], "R10", "stream order",
                        32'(rdata), 32'(model[0]));
                  void'(model.pop_front());
                  rd_en_n = 1'b0;
                  got++;
               end else begin
                  rd_en_n = 1'b1;
               end
            end
            @(negedge rclk);
            rd_en_n = 1'b1;
         end
      join
      repeat (6) @(posedge rclk);
      #1 check(out_ready == 1'b0 && model.size() == 0, "R10", "stream fully drained",
               32'(out_ready), 0);
   endtask

   initial begin
      #(WCLK_PERIOD * 150000);
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=hang expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset_flush();
      t_first_word();
      t_read_blocked();
      t_write_qual();
      t_fill();
      t_stream();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule